// File: doc/BRIEF.md
# Alphanumeric Display Register Interface

This block sits between a host microprocessor bus and the refresh engine of an eight-character dot-matrix display controller. The host drives a chip-enable, a write strobe, a read strobe, a flash-select line, five address lines and an eight-bit data byte. The block samples these in its own clock domain and turns each enabled access into exactly one write or read of one of five storage sections: the character store, the per-digit flash attribute bits, the user-glyph pointer, the user-glyph row store and the control byte.

The refresh engine reads the character store, the flash bits, the glyph rows and the control byte through dedicated combinational read ports. The block also runs two preload sequences. After reset is released, and for a fixed number of cycles after the host sets the clear bit of the control byte, it raises a busy output and ignores host writes. Both sequences leave blanks (0x20) in every character slot.

Top module: `disp_regif`

## Requirements
- R1: With hs_flash_n low the flash attribute bits are addressed and hs_addr[4:3] are ignored; with hs_flash_n high, hs_addr[4:3] = 00 picks the glyph pointer, 01 the glyph row store, 10 the control byte and 11 the character store.
- R2: An access happens only while hs_ce_n is low together with hs_we_n or hs_re_n low, and at most one access happens per low period of hs_ce_n.
- R3: Each character slot holds a full byte: bit 7 = 0 tags an ASCII code in bits 6..0, bit 7 = 1 tags a user glyph number in bits 3..0. Slot 0 is the leftmost digit and slot 7 the rightmost, and rf_char shows the slot chosen by rf_digit.
- R4: A glyph pointer write keeps data bits 3..0. A pointer read returns them with bits 7..4 as zero.
- R5: A glyph row write stores data bits 4..0 at the row hs_addr[2:0] (000 = first row, 110 = seventh row) of the glyph the pointer names. Data bits 7..5 are dropped. Bit 4 is the leftmost column, and rf_dots shows the row chosen by rf_glyph and rf_row.
- R6: A flash write sets the bit of the addressed digit to data bit 0. A flash read returns that bit in bit 0, and rf_flash shows the bit of rf_digit.
- R7: Reset loads 0x20 into every character slot and zero into the flash bits and the control byte. It leaves the glyph pointer and the glyph rows unchanged, and it keeps busy high for at least three cycles after release.
- R8: A control write with bit 7 set keeps busy high for the three following cycles. In that time every character slot becomes 0x20 and every flash bit becomes 1. Bit 7 then reads 0 again, and the other control bits keep the written value.
- R9: A control write replaces all control bits at once except bit 5. Bit 5 always reads the selftest_ok input, on the host read and on rf_ctrl alike.
- R10: A write issued while busy is high changes no state.
- R11: A read presents the addressed byte on hs_rdata with hs_rvalid high in the cycle after the access is sampled, and hs_rvalid is low in the cycle that follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hs_ce_n | input | 1 | Host chip enable, active low |
| hs_we_n | input | 1 | Host write strobe, active low |
| hs_re_n | input | 1 | Host read strobe, active low |
| hs_flash_n | input | 1 | Low selects the flash attribute bits |
| hs_addr | input | 5 | Section select [4:3] and index [2:0] |
| hs_wdata | input | 8 | Host write data |
| hs_rdata | output | 8 | Host read data |
| hs_rvalid | output | 1 | One-cycle pulse marking hs_rdata valid |
| busy | output | 1 | Reset or clear preload in progress |
| selftest_ok | input | 1 | Self-test result shown in control bit 5 |
| rf_digit | input | 3 | Refresh digit index |
| rf_char | output | 8 | Character byte of rf_digit |
| rf_flash | output | 1 | Flash bit of rf_digit |
| rf_glyph | input | 4 | Refresh glyph number |
| rf_row | input | 3 | Refresh glyph row |
| rf_dots | output | 5 | Dot pattern of that glyph row |
| rf_ctrl | output | 8 | Control byte as the refresh engine sees it |

## Verification
The bench builds the block with its default parameters: eight digits, sixteen glyphs of seven five-dot rows, and a three-cycle preload. With these values the leftmost and rightmost digits, the seventh glyph row and glyph 3 all fall inside the tested addresses, and the busy window is short enough to check one cycle at a time. Holding the host strobes low through the release of reset places a write inside the busy window. Toggling selftest_ok shows that control bit 5 cannot be written.

// File: rtl/disp_regif_pkg.sv
package disp_regif_pkg;
  localparam int unsigned BYTE_W = 8;
  localparam logic [BYTE_W-1:0] BLANK_CODE = 8'h20;
  localparam int unsigned CW_CLEAR_BIT = 7;
  localparam int unsigned CW_TEST_BIT  = 5;

  typedef enum logic [2:0] {
    SEC_FLASH,
    SEC_GPTR,
    SEC_GROW,
    SEC_CTRL,
    SEC_CHAR
  } sec_e;

  typedef enum logic [1:0] {
    SQ_IDLE,
    SQ_INIT,
    SQ_CLEAR
  } seq_e;
endpackage

// File: rtl/disp_regif_decode.sv
module disp_regif_decode
  import disp_regif_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ce_n,
  input  logic       we_n,
  input  logic       re_n,
  input  logic       flash_n,
  input  logic [1:0] sel_hi,
  output logic       wr_fire,
  output logic       rd_fire,
  output sec_e       sec
);
  logic armed_q, armed_d, strobe, fire;

  // an access needs chip enable plus one strobe, once per enable period
  assign strobe  = !ce_n && (!we_n || !re_n);
  assign fire    = strobe && armed_q;
  assign wr_fire = fire && !we_n;
  assign rd_fire = fire && we_n;

  always_comb begin
    armed_d = armed_q;
    if (ce_n)      armed_d = 1'b1;
    else if (fire) armed_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) armed_q <= 1'b1;
    else        armed_q <= armed_d;
  end

  always_comb begin
    if (!flash_n) sec = SEC_FLASH;
    else begin
      unique case (sel_hi)
        2'b00:   sec = SEC_GPTR;
        2'b01:   sec = SEC_GROW;
        2'b10:   sec = SEC_CTRL;
        default: sec = SEC_CHAR;
      endcase
    end
  end

  p_single_access_r2: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> !fire);
endmodule

// File: rtl/disp_regif_seq.sv
module disp_regif_seq
  import disp_regif_pkg::*;
#(
  parameter int unsigned SEQ_CYCLES = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_clr,
  output logic busy,
  output logic fill_clr,
  output logic clr_done
);
  localparam int unsigned CNT_W = $clog2(SEQ_CYCLES + 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  seq_e             mode_q, mode_d;

  always_comb begin
    cnt_d  = cnt_q;
    mode_d = mode_q;
    if (cnt_q != '0) begin
      cnt_d = cnt_q - 1'b1;
      if (cnt_q == CNT_W'(1)) mode_d = SQ_IDLE;
    end else if (start_clr) begin
      cnt_d  = CNT_W'(SEQ_CYCLES);
      mode_d = SQ_CLEAR;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= CNT_W'(SEQ_CYCLES);
      mode_q <= SQ_INIT;
    end else begin
      cnt_q  <= cnt_d;
      mode_q <= mode_d;
    end
  end

  assign busy     = (cnt_q != '0);
  assign fill_clr = (mode_q == SQ_CLEAR) && busy;
  assign clr_done = (mode_q == SQ_CLEAR) && (cnt_q == CNT_W'(1));

  p_done_frees_r8: assert property (@(posedge clk) disable iff (!rst_n)
    clr_done |=> !busy);
  p_clear_holds_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (start_clr && !busy) |=> (busy && fill_clr));
endmodule

// File: rtl/disp_regif_store.sv
module disp_regif_store
  import disp_regif_pkg::*;
#(
  parameter int unsigned DIGITS = 8
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      fill_clr,
  input  logic                      char_we,
  input  logic                      flash_we,
  input  logic [$clog2(DIGITS)-1:0] wr_idx,
  input  logic [BYTE_W-1:0]         wdata,
  input  logic [$clog2(DIGITS)-1:0] host_idx,
  input  logic [$clog2(DIGITS)-1:0] rf_idx,
  output logic [BYTE_W-1:0]         host_char,
  output logic                      host_flash,
  output logic [BYTE_W-1:0]         rf_char,
  output logic                      rf_flash
);
  localparam int unsigned DIG_AW = $clog2(DIGITS);

  logic [BYTE_W-1:0] char_q [DIGITS];
  logic [DIGITS-1:0] flash_q;

  for (genvar g = 0; g < DIGITS; g++) begin : g_slot
    logic hit;
    assign hit = (wr_idx == DIG_AW'(g));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                char_q[g] <= BLANK_CODE;
      else if (fill_clr)         char_q[g] <= BLANK_CODE;
      else if (char_we && hit)   char_q[g] <= wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                flash_q[g] <= 1'b0;
      else if (fill_clr)         flash_q[g] <= 1'b1;
      else if (flash_we && hit)  flash_q[g] <= wdata[0];
    end
  end

  assign host_char  = char_q[host_idx];
  assign host_flash = flash_q[host_idx];
  assign rf_char    = char_q[rf_idx];
  assign rf_flash   = flash_q[rf_idx];

  p_fill_chars_r8: assert property (@(posedge clk) disable iff (!rst_n)
    fill_clr |=> (char_q[DIGITS-1] == BLANK_CODE && char_q[0] == BLANK_CODE));
  p_fill_flash_r8: assert property (@(posedge clk) disable iff (!rst_n)
    fill_clr |=> (&flash_q));
endmodule

// File: rtl/disp_regif_glyph.sv
module disp_regif_glyph #(
  parameter int unsigned GLYPHS = 16,
  parameter int unsigned ROWS   = 7,
  parameter int unsigned COLS   = 5
) (
  input  logic                      clk,
  input  logic                      ptr_we,
  input  logic                      row_we,
  input  logic [$clog2(GLYPHS)-1:0] ptr_wdata,
  input  logic [COLS-1:0]           row_wdata,
  input  logic [$clog2(ROWS)-1:0]   host_row,
  input  logic [$clog2(GLYPHS)-1:0] rf_glyph,
  input  logic [$clog2(ROWS)-1:0]   rf_row,
  output logic [$clog2(GLYPHS)-1:0] ptr,
  output logic [COLS-1:0]           host_dots,
  output logic [COLS-1:0]           rf_dots
);
  localparam int unsigned ENTRIES = GLYPHS * ROWS;
  localparam int unsigned IDX_W   = $clog2(ENTRIES);

  logic [$clog2(GLYPHS)-1:0] ptr_q;
  logic [COLS-1:0]           mem_q [ENTRIES];
  logic                      host_ok, rf_ok;
  logic [IDX_W-1:0]          host_idx, rf_idx;

  assign host_ok  = (int'(host_row) < ROWS);
  assign rf_ok    = (int'(rf_row) < ROWS);
  assign host_idx = host_ok ? IDX_W'(int'(ptr_q) * ROWS + int'(host_row)) : '0;
  assign rf_idx   = rf_ok ? IDX_W'(int'(rf_glyph) * ROWS + int'(rf_row)) : '0;

  // glyph contents survive reset, so these registers carry none
  always_ff @(posedge clk) begin
    if (ptr_we) ptr_q <= ptr_wdata;
  end

  always_ff @(posedge clk) begin
    if (row_we && host_ok) mem_q[host_idx] <= row_wdata;
  end

  assign ptr       = ptr_q;
  assign host_dots = host_ok ? mem_q[host_idx] : '0;
  assign rf_dots   = rf_ok ? mem_q[rf_idx] : '0;
endmodule

// File: rtl/disp_regif.sv
module disp_regif
  import disp_regif_pkg::*;
#(
  parameter int unsigned DIGITS     = 8,
  parameter int unsigned GLYPHS     = 16,
  parameter int unsigned ROWS       = 7,
  parameter int unsigned COLS       = 5,
  parameter int unsigned SEQ_CYCLES = 3
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        hs_ce_n,
  input  logic                        hs_we_n,
  input  logic                        hs_re_n,
  input  logic                        hs_flash_n,
  input  logic [$clog2(DIGITS)+1:0]   hs_addr,
  input  logic [7:0]                  hs_wdata,
  output logic [7:0]                  hs_rdata,
  output logic                        hs_rvalid,
  output logic                        busy,
  input  logic                        selftest_ok,
  input  logic [$clog2(DIGITS)-1:0]   rf_digit,
  output logic [7:0]                  rf_char,
  output logic                        rf_flash,
  input  logic [$clog2(GLYPHS)-1:0]   rf_glyph,
  input  logic [$clog2(ROWS)-1:0]     rf_row,
  output logic [COLS-1:0]             rf_dots,
  output logic [7:0]                  rf_ctrl
);
  localparam int unsigned DIG_AW = $clog2(DIGITS);
  localparam int unsigned GLY_AW = $clog2(GLYPHS);
  localparam int unsigned ROW_AW = $clog2(ROWS);
  localparam logic [BYTE_W-1:0] TEST_MASK = BYTE_W'(1) << CW_TEST_BIT;

  // reset asserted asynchronously, released on the clock
  logic [1:0] rsync_q;
  logic       irst_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign irst_n = rsync_q[1];

  logic wr_fire, rd_fire, fill_clr, clr_done, wr_ok;
  sec_e sec;

  disp_regif_decode u_decode (
    .clk     (clk),
    .rst_n   (irst_n),
    .ce_n    (hs_ce_n),
    .we_n    (hs_we_n),
    .re_n    (hs_re_n),
    .flash_n (hs_flash_n),
    .sel_hi  (hs_addr[DIG_AW+1:DIG_AW]),
    .wr_fire (wr_fire),
    .rd_fire (rd_fire),
    .sec     (sec)
  );

  assign wr_ok = wr_fire && !busy;

  logic ctrl_we, start_clr;
  assign ctrl_we   = wr_ok && (sec == SEC_CTRL);
  assign start_clr = ctrl_we && hs_wdata[CW_CLEAR_BIT];

  disp_regif_seq #(.SEQ_CYCLES(SEQ_CYCLES)) u_seq (
    .clk       (clk),
    .rst_n     (irst_n),
    .start_clr (start_clr),
    .busy      (busy),
    .fill_clr  (fill_clr),
    .clr_done  (clr_done)
  );

  logic [7:0] host_char;
  logic       host_flash;

  disp_regif_store #(.DIGITS(DIGITS)) u_store (
    .clk        (clk),
    .rst_n      (irst_n),
    .fill_clr   (fill_clr),
    .char_we    (wr_ok && (sec == SEC_CHAR)),
    .flash_we   (wr_ok && (sec == SEC_FLASH)),
    .wr_idx     (hs_addr[DIG_AW-1:0]),
    .wdata      (hs_wdata),
    .host_idx   (hs_addr[DIG_AW-1:0]),
    .rf_idx     (rf_digit),
    .host_char  (host_char),
    .host_flash (host_flash),
    .rf_char    (rf_char),
    .rf_flash   (rf_flash)
  );

  logic [GLY_AW-1:0] gptr;
  logic [COLS-1:0]   host_dots;

  disp_regif_glyph #(.GLYPHS(GLYPHS), .ROWS(ROWS), .COLS(COLS)) u_glyph (
    .clk       (clk),
    .ptr_we    (wr_ok && (sec == SEC_GPTR)),
    .row_we    (wr_ok && (sec == SEC_GROW)),
    .ptr_wdata (hs_wdata[GLY_AW-1:0]),
    .row_wdata (hs_wdata[COLS-1:0]),
    .host_row  (hs_addr[ROW_AW-1:0]),
    .rf_glyph  (rf_glyph),
    .rf_row    (rf_row),
    .ptr       (gptr),
    .host_dots (host_dots),
    .rf_dots   (rf_dots)
  );

  // control byte; the test bit is never stored, it comes from selftest_ok
  logic [7:0] ctrl_q, ctrl_d, ctrl_view;
  always_comb begin
    ctrl_d = ctrl_q;
    if (ctrl_we)       ctrl_d = hs_wdata & ~TEST_MASK;
    else if (clr_done) ctrl_d[CW_CLEAR_BIT] = 1'b0;
  end

  always_ff @(posedge clk or negedge irst_n) begin
    if (!irst_n) ctrl_q <= '0;
    else         ctrl_q <= ctrl_d;
  end

  assign ctrl_view = ctrl_q | (selftest_ok ? TEST_MASK : '0);
  assign rf_ctrl   = ctrl_view;

  logic [7:0] rd_byte, rdata_q;
  logic       rvalid_q;
  always_comb begin
    unique case (sec)
      SEC_FLASH: rd_byte = 8'(host_flash);
      SEC_GPTR:  rd_byte = 8'(gptr);
      SEC_GROW:  rd_byte = 8'(host_dots);
      SEC_CTRL:  rd_byte = ctrl_view;
      default:   rd_byte = host_char;
    endcase
  end

  always_ff @(posedge clk or negedge irst_n) begin
    if (!irst_n) begin
      rdata_q  <= '0;
      rvalid_q <= 1'b0;
    end else begin
      rvalid_q <= rd_fire;
      if (rd_fire) rdata_q <= rd_byte;
    end
  end

  assign hs_rdata  = rdata_q;
  assign hs_rvalid = rvalid_q;

  p_clear_ends_r8: assert property (@(posedge clk) disable iff (!irst_n)
    $fell(busy) |-> !ctrl_q[CW_CLEAR_BIT]);
  p_read_valid_r11: assert property (@(posedge clk) disable iff (!irst_n)
    rd_fire |=> hs_rvalid);
  p_rvalid_pulse_r11: assert property (@(posedge clk) disable iff (!irst_n)
    (hs_rvalid && hs_ce_n) |=> !hs_rvalid);
  p_busy_drop_r10: assert property (@(posedge clk) disable iff (!irst_n)
    (busy && wr_fire && sec == SEC_CTRL && !clr_done) |=> $stable(ctrl_q));
  p_test_bit_r9: assert property (@(posedge clk) disable iff (!irst_n)
    rf_ctrl[CW_TEST_BIT] == selftest_ok);
endmodule

// File: tb/disp_regif_tb_top.sv
module disp_regif_tb_top;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       hs_ce_n, hs_we_n, hs_re_n, hs_flash_n;
  logic [4:0] hs_addr;
  logic [7:0] hs_wdata, hs_rdata, rf_char, rf_ctrl;
  logic       hs_rvalid, busy, selftest_ok, rf_flash;
  logic [2:0] rf_digit, rf_row;
  logic [3:0] rf_glyph;
  logic [4:0] rf_dots;

  int total = 0;
  int bad   = 0;

  always #4 clk = ~clk;

  disp_regif dut_i (
    .clk(clk), .rst_n(rst_n), .hs_ce_n(hs_ce_n), .hs_we_n(hs_we_n),
    .hs_re_n(hs_re_n), .hs_flash_n(hs_flash_n), .hs_addr(hs_addr),
    .hs_wdata(hs_wdata), .hs_rdata(hs_rdata), .hs_rvalid(hs_rvalid),
    .busy(busy), .selftest_ok(selftest_ok), .rf_digit(rf_digit),
    .rf_char(rf_char), .rf_flash(rf_flash), .rf_glyph(rf_glyph),
    .rf_row(rf_row), .rf_dots(rf_dots), .rf_ctrl(rf_ctrl)
  );

  // vector: [22] write, [21] flash_n, [20:16] addr, [15:8] data, [7:0] expected read
  localparam int NV = 18;
  localparam logic [22:0] VEC [NV] = '{
    {1'b1, 1'b1, 5'b11000, 8'h41, 8'h00},  // R3 ASCII in leftmost slot
    {1'b1, 1'b1, 5'b11111, 8'h85, 8'h00},  // R3 glyph tag in rightmost slot
    {1'b0, 1'b1, 5'b11000, 8'h00, 8'h41},
    {1'b0, 1'b1, 5'b11111, 8'h00, 8'h85},
    {1'b1, 1'b1, 5'b00110, 8'hF3, 8'h00},  // R4 upper bits dropped
    {1'b0, 1'b1, 5'b00101, 8'h00, 8'h03},
    {1'b1, 1'b1, 5'b01000, 8'hFF, 8'h00},  // R5 first row, bits 7..5 dropped
    {1'b1, 1'b1, 5'b01110, 8'h0A, 8'h00},  // R5 seventh row
    {1'b0, 1'b1, 5'b01000, 8'h00, 8'h1F},
    {1'b0, 1'b1, 5'b01110, 8'h00, 8'h0A},
    {1'b1, 1'b0, 5'b11010, 8'h01, 8'h00},  // R1 R6 high bits ignored
    {1'b1, 1'b0, 5'b00101, 8'hFE, 8'h00},  // R6 bit 0 = 0 removes
    {1'b0, 1'b0, 5'b01010, 8'h00, 8'h01},
    {1'b0, 1'b0, 5'b10101, 8'h00, 8'h00},
    {1'b1, 1'b1, 5'b10011, 8'h25, 8'h00},  // R9 bit 5 not writable
    {1'b0, 1'b1, 5'b10000, 8'h00, 8'h25},
    {1'b1, 1'b1, 5'b10000, 8'h1B, 8'h00},
    {1'b0, 1'b1, 5'b10000, 8'h00, 8'h3B}
  };

  function automatic string tag_of(input logic fl, input logic [1:0] hi);
    if (!fl) return "R6";
    case (hi)
      2'b00:   return "R4";
      2'b01:   return "R5";
      2'b10:   return "R9";
      default: return "R3";
    endcase
  endfunction

  task automatic chk(input string req, input logic [7:0] got, input logic [7:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  task automatic acc(input logic wr, input logic fl, input logic [4:0] a,
                     input logic [7:0] d, output logic [7:0] rd, output logic rv);
    @(negedge clk);
    hs_flash_n = fl; hs_addr = a; hs_wdata = d; hs_ce_n = 1'b0;
    if (wr) hs_we_n = 1'b0; else hs_re_n = 1'b0;
    @(negedge clk);
    rd = hs_rdata; rv = hs_rvalid;
    hs_ce_n = 1'b1; hs_we_n = 1'b1; hs_re_n = 1'b1;
  endtask

  task automatic wr(input logic fl, input logic [4:0] a, input logic [7:0] d);
    logic [7:0] r; logic v;
    acc(1'b1, fl, a, d, r, v);
  endtask

  task automatic rd(input string req, input logic fl, input logic [4:0] a, input logic [7:0] exp);
    logic [7:0] r; logic v;
    acc(1'b0, fl, a, 8'h00, r, v);
    chk(req, r, exp);
  endtask

  task automatic wait_idle(input string req);
    int n = 0;
    while (busy && n < 20) begin @(negedge clk); n++; end
    chk(req, 8'(busy), 8'h00);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired got=running exp=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [7:0] r; logic v;
    int n;
    rst_n = 1'b0; hs_ce_n = 1'b1; hs_we_n = 1'b1; hs_re_n = 1'b1;
    hs_flash_n = 1'b1; hs_addr = '0; hs_wdata = '0; selftest_ok = 1'b1;
    rf_digit = '0; rf_glyph = '0; rf_row = '0;
    repeat (3) @(negedge clk);
    chk("R7 busy in reset", 8'(busy), 8'h01);
    chk("R11 no valid in reset", 8'(hs_rvalid), 8'h00);
    rst_n = 1'b1;
    n = 0;
    while (busy && n < 20) begin @(negedge clk); n++; end
    chk("R7 busy length at least 3", 8'(n >= 3 && n <= 8), 8'h01);
    rd("R7 blank char", 1'b1, 5'b11011, 8'h20);
    rd("R7 flash zero", 1'b0, 5'b00000, 8'h00);
    rd("R7 ctrl zero", 1'b1, 5'b10000, 8'h20);

    for (int i = 0; i < NV; i++) begin
      acc(VEC[i][22], VEC[i][21], VEC[i][20:16], VEC[i][15:8], r, v);
      if (!VEC[i][22]) begin
        chk(tag_of(VEC[i][21], VEC[i][20:19]), r, VEC[i][7:0]);
        chk("R11 rvalid", 8'(v), 8'h01);
      end
    end
    @(negedge clk);
    chk("R11 rvalid drops", 8'(hs_rvalid), 8'h00);

    // refresh ports
    rf_digit = 3'd7; #1; chk("R3 rf_char right", rf_char, 8'h85);
    rf_digit = 3'd0; #1; chk("R3 rf_char left", rf_char, 8'h41);
    rf_digit = 3'd2; #1; chk("R6 rf_flash", 8'(rf_flash), 8'h01);
    rf_glyph = 4'd3; rf_row = 3'd0; #1; chk("R5 rf_dots row1", 8'(rf_dots), 8'h1F);
    rf_row = 3'd6; #1; chk("R5 rf_dots row7", 8'(rf_dots), 8'h0A);
    chk("R9 rf_ctrl", rf_ctrl, 8'h3B);
    selftest_ok = 1'b0;
    rd("R9 test bit follows input", 1'b1, 5'b10000, 8'h1B);
    selftest_ok = 1'b1;

    // R2: no access without both enable and strobe, one per enable period
    @(negedge clk); hs_addr = 5'b11000; hs_wdata = 8'h11; hs_we_n = 1'b0;
    @(negedge clk); hs_we_n = 1'b1; hs_ce_n = 1'b0;
    @(negedge clk); hs_ce_n = 1'b1;
    rd("R2 strobe without enable", 1'b1, 5'b11000, 8'h41);
    @(negedge clk); hs_flash_n = 1'b1; hs_addr = 5'b11000; hs_ce_n = 1'b0;
    hs_wdata = 8'h50; hs_we_n = 1'b0;
    @(negedge clk); hs_we_n = 1'b1;
    @(negedge clk); hs_wdata = 8'h51; hs_we_n = 1'b0;
    @(negedge clk); hs_we_n = 1'b1; hs_ce_n = 1'b1;
    rd("R2 one access per enable", 1'b1, 5'b11000, 8'h50);

    // R8: clear sequence
    @(negedge clk);
    hs_flash_n = 1'b1; hs_addr = 5'b10000; hs_wdata = 8'h9B; hs_ce_n = 1'b0; hs_we_n = 1'b0;
    @(negedge clk); hs_ce_n = 1'b1; hs_we_n = 1'b1;
    chk("R8 busy cycle 1", 8'(busy), 8'h01);
    @(negedge clk); chk("R8 busy cycle 2", 8'(busy), 8'h01);
    @(negedge clk); chk("R8 busy cycle 3", 8'(busy), 8'h01);
    @(negedge clk); chk("R8 busy released", 8'(busy), 8'h00);
    rd("R8 clear bit returns", 1'b1, 5'b10000, 8'h3B);
    rd("R8 blank right", 1'b1, 5'b11111, 8'h85 & 8'h20 | 8'h20);
    rd("R8 blank left", 1'b1, 5'b11000, 8'h20);
    rd("R8 flash ones", 1'b0, 5'b00000, 8'h01);
    rd("R8 flash ones 2", 1'b0, 5'b00010, 8'h01);
    rd("R8 pointer kept", 1'b1, 5'b00000, 8'h03);

    // R10 + R7: write held across reset release lands in busy window
    @(negedge clk);
    hs_flash_n = 1'b1; hs_addr = 5'b00000; hs_wdata = 8'h09;
    hs_ce_n = 1'b0; hs_we_n = 1'b0;
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    wait_idle("R7 busy ends");
    hs_ce_n = 1'b1; hs_we_n = 1'b1;
    rd("R10 write while busy dropped", 1'b1, 5'b00000, 8'h03);
    rd("R7 glyph rows kept", 1'b1, 5'b01110, 8'h0A);
    rd("R7 flash cleared", 1'b0, 5'b00010, 8'h00);
    rd("R7 ctrl cleared", 1'b1, 5'b10000, 8'h20);
    rd("R7 char blank", 1'b1, 5'b11001, 8'h20);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule